// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block is the slave end of a three-wire stereo audio link. Bit clock, word select and serial data all come from outside. Each is brought into the system-clock domain through a two-flop synchronizer, and the data line is sampled on every detected rising edge of the bit clock. A two-bit format input picks one of four framings. The first is the framing in which the most significant bit trails the word-select edge by one bit period. The other three are right-aligned framings in which the last 16, 18 or 20 bits of each channel slot carry the word.

Recovered words are presented as 20-bit two's-complement samples on a valid/ready output stream, one transfer per left/right pair. Shorter words are left-aligned with zeros below them, so full scale is the same in every format. The serial link cannot be paused, so back-pressure never stalls the input. While `smp_valid_o` is high and `smp_ready_i` is low, the pair on the outputs is held. If another pair completes before the sink accepts, that newer pair replaces the held one and valid stays high. A transfer happens on any clock edge where valid and ready are both high.

The system clock is assumed frequency-locked to the link. A select bit states whether it runs at 256 or 384 times the sample rate, and the block reports that choice back.

Top module: `audio_serial_rx`

## Requirements
- R1: After reset, `smp_valid_o` is low and both sample outputs are zero.
- R2: Format code 00 selects delayed framing. The bit sampled at the first bit-clock rise after word select changes still belongs to the old channel. The next bit is the most significant bit of the new word. Word select low marks the left channel and high marks the right channel.
- R3: In format 00, only the first 20 bits of a slot are kept, and any later bits in that slot have no effect on the output.
- R4: In format 00, a word shorter than 20 bits is output left-aligned in 20 bits, with zeros below it.
- R5: Format code 01 captures the last 16 bits of each slot. The output is that word followed by 4 zero bits, and earlier bits in the slot are ignored.
- R6: Format code 10 captures the last 18 bits of each slot. The output is that word followed by 2 zero bits, and earlier bits in the slot are ignored.
- R7: Format code 11 captures the last 20 bits of each slot, and earlier bits in the slot are ignored.
- R8: A pair is offered when a complete right slot ends after a complete left slot. Valid rises on the third system-clock edge after the bit-clock rise that opens the next left slot. With ready high, valid lasts exactly one cycle.
- R9: While valid is high and ready is low, valid stays high. A newer completed pair replaces the held one.
- R10: After reset or a change of the format input, slots whose opening boundary was not seen are dropped. The first pair is the first frame whose left slot began after the block had locked onto the channel boundaries. Valid never rises in the cycle after a format change.
- R11: `ratio_384_o` reports the ratio select one cycle after it is applied: 0 means 256 and 1 means 384 times the sample rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock from the bus master |
| wsel_i | input | 1 | Word select (0 left, 1 right) |
| sdata_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 2 | Framing: 00 delayed, 01/10/11 right-aligned 16/18/20 |
| ratio_sel_i | input | 1 | System-clock ratio select (0 = 256x, 1 = 384x) |
| ratio_384_o | output | 1 | Registered ratio report |
| smp_valid_o | output | 1 | A left/right pair is available |
| smp_ready_i | input | 1 | Sink accepts the pair |
| smp_left_o | output | 20 | Left sample, two's complement, left-aligned |
| smp_right_o | output | 20 | Right sample, two's complement, left-aligned |

## Verification
A pair is due exactly three system-clock edges after the bit-clock rise that opens the following left slot. The bench notes the cycle counter when it drives that rise and compares it with the counter at the first sample that shows valid high. All sampling is done on falling clock edges, midway between active edges. The ratio report is due one edge after the select changes, and the bench reads it two falling edges later. Outputs under back-pressure are read after the link has gone idle and before ready is raised, so that any later replacement or loss of the held pair is visible.

// File: rtl/asr_pkg.sv
package asr_pkg;
  typedef enum logic [1:0] {
    FMT_DLY  = 2'b00,
    FMT_RJ16 = 2'b01,
    FMT_RJ18 = 2'b10,
    FMT_RJ20 = 2'b11
  } fmt_e;

  localparam int SAMPLE_W = 20;

  typedef struct packed {
    logic                fin;
    logic                ok;
    logic                ch;
    logic [SAMPLE_W-1:0] word;
  } slot_res_t;
endpackage

// File: rtl/asr_sync.sv
module asr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/asr_slot_deser.sv
module asr_slot_deser
  import asr_pkg::*;
#(
  parameter int SLOT_MAX = 32
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      rise,
  input  logic      ws,
  input  logic      sd,
  input  fmt_e      fmt,
  output slot_res_t res
);
  localparam int CNT_W = $clog2(SLOT_MAX + 1);
  localparam logic [CNT_W-1:0] OUTW_C = CNT_W'(SAMPLE_W);
  localparam logic [CNT_W-1:0] SMAX_C = CNT_W'(SLOT_MAX);

  logic                wsv, ws_last, armed, prev_ch, started;
  logic [SLOT_MAX-1:0] sreg;
  logic [CNT_W-1:0]    cnt;

  logic                ch, accept;
  logic [CNT_W-1:0]    sh;
  logic [SAMPLE_W-1:0] dly_word, rj_word;

  // channel of the bit under the current rise
  assign ch     = (fmt == FMT_DLY) ? ws_last : ws;
  assign accept = (fmt == FMT_DLY) ? (cnt < OUTW_C) : 1'b1;

  always_comb begin
    sh       = (cnt >= OUTW_C) ? '0 : (OUTW_C - cnt);
    dly_word = sreg[SAMPLE_W-1:0] << sh;
    case (fmt)
      FMT_RJ16: rj_word = SAMPLE_W'(sreg[15:0]) << (SAMPLE_W - 16);
      FMT_RJ18: rj_word = SAMPLE_W'(sreg[17:0]) << (SAMPLE_W - 18);
      default:  rj_word = SAMPLE_W'(sreg[19:0]) << (SAMPLE_W - 20);
    endcase
  end

  always_comb begin
    res.fin  = rise && wsv && armed && !clr && (ch != prev_ch);
    res.ok   = started;
    res.ch   = prev_ch;
    res.word = (fmt == FMT_DLY) ? dly_word : rj_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsv     <= 1'b0;
      ws_last <= 1'b0;
      armed   <= 1'b0;
      prev_ch <= 1'b0;
      started <= 1'b0;
      sreg    <= '0;
      cnt     <= '0;
    end else if (clr) begin
      armed   <= 1'b0;
      started <= 1'b0;
    end else if (rise) begin
      ws_last <= ws;
      wsv     <= 1'b1;
      if (wsv) begin
        if (!armed) begin
          armed   <= 1'b1;
          prev_ch <= ch;
          started <= 1'b0;
          sreg    <= SLOT_MAX'(sd);
          cnt     <= CNT_W'(1);
        end else if (ch != prev_ch) begin
          prev_ch <= ch;
          started <= 1'b1;
          sreg    <= SLOT_MAX'(sd);
          cnt     <= CNT_W'(1);
        end else if (accept) begin
          sreg <= {sreg[SLOT_MAX-2:0], sd};
          if (cnt < SMAX_C) cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/asr_pair_out.sv
module asr_pair_out
  import asr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  slot_res_t           res,
  input  logic                ready,
  output logic                valid,
  output logic [SAMPLE_W-1:0] left,
  output logic [SAMPLE_W-1:0] right
);
  logic                left_ok;
  logic [SAMPLE_W-1:0] left_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid     <= 1'b0;
      left      <= '0;
      right     <= '0;
      left_ok   <= 1'b0;
      left_hold <= '0;
    end else begin
      if (valid && ready) valid <= 1'b0;
      if (clr) begin
        left_ok <= 1'b0;
      end else if (res.fin) begin
        if (!res.ch) begin
          left_ok   <= res.ok;
          left_hold <= res.word;
        end else begin
          left_ok <= 1'b0;
          if (res.ok && left_ok) begin
            left  <= left_hold;
            right <= res.word;
            valid <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import asr_pkg::*;
#(
  parameter int SLOT_MAX    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_i,
  input  logic                wsel_i,
  input  logic                sdata_i,
  input  logic [1:0]          fmt_i,
  input  logic                ratio_sel_i,
  output logic                ratio_384_o,
  output logic                smp_valid_o,
  input  logic                smp_ready_i,
  output logic [SAMPLE_W-1:0] smp_left_o,
  output logic [SAMPLE_W-1:0] smp_right_o
);
  logic [2:0] bus_s;
  logic       bclk_q, rise, clr;
  fmt_e       fmt_cur, fmt_q;
  slot_res_t  res;

  asr_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({bclk_i, wsel_i, sdata_i}),
    .q    (bus_s)
  );

  assign fmt_cur = fmt_e'(fmt_i);
  assign rise    = bus_s[2] && !bclk_q;
  assign clr     = (fmt_cur != fmt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q      <= 1'b0;
      fmt_q       <= FMT_DLY;
      ratio_384_o <= 1'b0;
    end else begin
      bclk_q      <= bus_s[2];
      fmt_q       <= fmt_cur;
      ratio_384_o <= ratio_sel_i;
    end
  end

  asr_slot_deser #(.SLOT_MAX(SLOT_MAX)) u_deser (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .rise (rise),
    .ws   (bus_s[1]),
    .sd   (bus_s[0]),
    .fmt  (fmt_cur),
    .res  (res)
  );

  asr_pair_out u_pair (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .res  (res),
    .ready(smp_ready_i),
    .valid(smp_valid_o),
    .left (smp_left_o),
    .right(smp_right_o)
  );
endmodule

// File: rtl/audio_serial_rx_chk.sv
module audio_serial_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bclk_i,
  input logic [1:0]  fmt_i,
  input logic        smp_valid_o,
  input logic        smp_ready_i,
  input logic [19:0] smp_left_o
);
  // R8
  valid_rise_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smp_valid_o) |-> ($past(bclk_i, 3) && !$past(bclk_i, 4)));

  // R8
  accept_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_o && smp_ready_i) |=>
      (!smp_valid_o || ($past(bclk_i, 3) && !$past(bclk_i, 4))));

  // R9
  held_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_o && !smp_ready_i) |=> smp_valid_o);

  // R9
  held_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_o && !smp_ready_i) |=>
      ($stable(smp_left_o) || ($past(bclk_i, 3) && !$past(bclk_i, 4))));

  // R10
  fmt_change_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_i != $past(fmt_i)) |=> !$rose(smp_valid_o));
endmodule

bind audio_serial_rx audio_serial_rx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bclk_i     (bclk_i),
  .fmt_i      (fmt_i),
  .smp_valid_o(smp_valid_o),
  .smp_ready_i(smp_ready_i),
  .smp_left_o (smp_left_o)
);

// File: tb/sim_audio_serial_rx.sv
`timescale 1ns/1ps
module sim_audio_serial_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, wsel = 1'b0, sdata = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic        ratio_sel = 1'b0, ratio_o;
  logic        vld, rdy = 1'b1;
  logic [19:0] lft, rgt;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, rise_cyc = 0;
  int ng = 0;
  logic [19:0] got_l [8];
  logic [19:0] got_r [8];
  logic [31:0] fl [4];
  logic [31:0] fr [4];
  int b_slot = 24, b_wl = 20;
  bit vld_prev = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  audio_serial_rx u0 (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .wsel_i(wsel), .sdata_i(sdata),
    .fmt_i(fmt), .ratio_sel_i(ratio_sel), .ratio_384_o(ratio_o),
    .smp_valid_o(vld), .smp_ready_i(rdy), .smp_left_o(lft), .smp_right_o(rgt)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: records accepted pairs and checks the R8 latency on each new valid
  always @(negedge clk) begin
    if (rst_n) begin
      if (vld && !vld_prev) chk((cyc - rise_cyc) == 3, "R8 latency", cyc - rise_cyc, 3);
      if (vld && rdy && ng < 8) begin
        got_l[ng] = lft;
        got_r[ng] = rgt;
        ng++;
      end
      vld_prev = vld;
    end else vld_prev = 1'b0;
  end

  function automatic logic [19:0] expw(input logic [31:0] w);
    int n;
    if (fmt == 2'b00) begin
      if (b_wl >= 20) return 20'(w >> (b_wl - 20));
      return 20'(w << (20 - b_wl));
    end
    n = (fmt == 2'b01) ? 16 : (fmt == 2'b10) ? 18 : 20;
    return 20'((w & ((32'd1 << n) - 32'd1)) << (20 - n));
  endfunction

  task automatic drive_bit(input logic s, input logic d);
    @(negedge clk);
    bclk = 1'b0; wsel = s; sdata = d;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    rise_cyc = cyc;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_slot(input logic c, input logic [31:0] w);
    for (int i = 0; i < b_slot; i++) begin
      logic d, s;
      int p;
      if (fmt == 2'b00) begin
        d = (i < b_wl) ? w[b_wl-1-i] : 1'b0;
        s = (i < b_slot - 1) ? c : ~c;
      end else begin
        p = b_slot - 1 - i;
        d = (p < b_wl) ? w[p] : 1'b1;
        s = c;
      end
      drive_bit(s, d);
    end
  endtask

  task automatic run_seq(input int n);
    ng = 0;
    for (int k = 0; k < n; k++) begin
      send_slot(1'b0, fl[k]);
      send_slot(1'b1, fr[k]);
    end
    drive_bit(1'b0, 1'b0);
    @(negedge clk); bclk = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic check_pairs(input int n, input string tag);
    chk(ng == n - 1, {tag, " pair count"}, ng, n - 1);
    for (int k = 1; k < n; k++) begin
      if (k - 1 < ng) begin
        chk(got_l[k-1] == expw(fl[k]), {tag, " left"}, got_l[k-1], expw(fl[k]));
        chk(got_r[k-1] == expw(fr[k]), {tag, " right"}, got_r[k-1], expw(fr[k]));
      end
    end
  endtask

  task automatic do_reset(input logic [1:0] f);
    rst_n = 1'b0; bclk = 1'b0; wsel = 1'b0; sdata = 1'b0; fmt = f;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ng = 0;
  endtask

  task automatic t_reset;
    do_reset(2'b00);
    chk(vld == 1'b0, "R1 valid", vld, 0);
    chk(lft == 20'h0, "R1 left", lft, 0);
    chk(rgt == 20'h0, "R1 right", rgt, 0);
  endtask

  task automatic t_ratio;
    ratio_sel = 1'b1; @(negedge clk); @(negedge clk);
    chk(ratio_o == 1'b1, "R11 384", ratio_o, 1);
    ratio_sel = 1'b0; @(negedge clk); @(negedge clk);
    chk(ratio_o == 1'b0, "R11 256", ratio_o, 0);
  endtask

  task automatic t_dly20;   // R2 R8 R10
    do_reset(2'b00); b_slot = 24; b_wl = 20;
    fl[0] = 32'h11111; fr[0] = 32'h22222;
    fl[1] = 32'h12345; fr[1] = 32'hABCDE;
    fl[2] = 32'h80001; fr[2] = 32'h7FFFF;
    run_seq(3);
    check_pairs(3, "R2 R10");
  endtask

  task automatic t_dly_long;  // R3
    do_reset(2'b00); b_slot = 32; b_wl = 24;
    fl[0] = 32'h0; fr[0] = 32'h0;
    fl[1] = 32'hA5C3E1; fr[1] = 32'h123456;
    fl[2] = 32'hFFFFFF; fr[2] = 32'h80000F;
    run_seq(3);
    check_pairs(3, "R3");
  endtask

  task automatic t_dly_short; // R4
    do_reset(2'b00); b_slot = 32; b_wl = 16;
    fl[0] = 32'h0; fr[0] = 32'h0;
    fl[1] = 32'h8001; fr[1] = 32'h7FFE;
    run_seq(2);
    check_pairs(2, "R4");
  endtask

  task automatic t_rj(input logic [1:0] f, input int n, input string tag); // R5 R6 R7
    do_reset(f); b_slot = 32; b_wl = n;
    fl[0] = 32'h0; fr[0] = 32'h0;
    fl[1] = 32'h2ABCD; fr[1] = 32'hFEDCB;
    fl[2] = 32'h00001; fr[2] = 32'h18000;
    run_seq(3);
    check_pairs(3, tag);
  endtask

  task automatic t_fmt_change; // R10
    fmt = 2'b01; b_slot = 24; b_wl = 16;
    repeat (6) @(negedge clk);
    fl[0] = 32'h1111; fr[0] = 32'h2222;
    fl[1] = 32'hC0DE; fr[1] = 32'h0BAD;
    fl[2] = 32'h7FFF; fr[2] = 32'h8000;
    run_seq(3);
    check_pairs(3, "R10 fmt change");
  endtask

  task automatic t_backpressure; // R9
    do_reset(2'b00); b_slot = 24; b_wl = 20;
    rdy = 1'b0;
    fl[0] = 32'h0;     fr[0] = 32'h0;
    fl[1] = 32'h13579; fr[1] = 32'h2468A;
    fl[2] = 32'hFACE1; fr[2] = 32'h0BEEF;
    run_seq(3);
    chk(ng == 0, "R9 nothing taken", ng, 0);
    chk(vld == 1'b1, "R9 valid held", vld, 1);
    chk(lft == expw(fl[2]), "R9 newest left", lft, expw(fl[2]));
    chk(rgt == expw(fr[2]), "R9 newest right", rgt, expw(fr[2]));
    @(posedge clk); #2 rdy = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(vld == 1'b0, "R9 accepted", vld, 0);
    chk(ng == 1, "R9 one transfer", ng, 1);
  endtask

  initial begin
    t_reset();
    t_ratio();
    t_dly20();
    t_dly_long();
    t_dly_short();
    t_rj(2'b01, 16, "R5");
    t_rj(2'b10, 18, "R6");
    t_rj(2'b11, 20, "R7");
    t_dly20();
    t_fmt_change();
    t_backpressure();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule